// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It produces the command sequence that must run after power-up, from the first stable clock until the memory can take normal traffic. A single `start` pulse begins the run. The block holds the clock-enable low while the supply settles. It then raises it under NOP commands and issues a fixed series of precharge-all, mode-register writes, DLL reset and refresh commands. It raises `initDone` only when every minimum spacing has been met and the DLL has had its lock time.

The mode settings are sampled on the cycle that `start` is accepted. These settings are CAS latency, burst length, additive latency, write recovery code and termination select. Every delay is a parameter counted in clock cycles. One down-counter, reloaded in each state, times the pre-CKE wait, the NOP window after CKE rises and the gap after each command. A second counter measures the DLL lock window from the DLL-reset write.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset and before `start`, `cke` is 0, the command pins show deselect (`csN`=1), `odt` is 0 and `initDone` is 0.
- R2: Once `start` is sampled, `cke` stays 0 with deselect for PRE_CKE_CYC cycles. It then rises and only NOPs (csN,rasN,casN,weN = 0111) are driven for CKE_NOP_CYC cycles. The first real command appears on the cycle after that.
- R3: Exactly eleven commands are issued, in this order: precharge-all, EMR2, EMR3, EMR1, MR with DLL reset, precharge-all, refresh, refresh, MR without DLL reset, EMR1 with OCD default, EMR1 with OCD exit. The pin encodings are: precharge 0010, refresh 0001, mode write 0000.
- R4: Every precharge-all drives address bit 10 high and all other address bits low.
- R5: EMR2 (bank 2) and EMR3 (bank 3) are written with every address bit zero.
- R6: MR writes use bank 0. The address carries burst length code on A2:A0, 0 on A3, CAS latency code on A6:A4 and 0 on A7. It also carries the DLL-reset flag on A8, the write-recovery code on A11:A9 and 0 on A12.
- R7: EMR1 writes use bank 1. The address carries 0 on A0 (DLL enabled), 0 on A1, termination select bit 0 on A2 and bit 1 on A6, and additive latency on A5:A3. The OCD field on A9:A7 is 000 on the first write, 111 on the default write and 000 on the exit write. A12:A10 are 0.
- R8: The command after a precharge-all comes exactly TRP_CYC cycles later. The command after a refresh comes exactly TRFC_CYC cycles later. The command after a mode write comes exactly TMRD_CYC cycles later. Each gap is raised to at least 2.
- R9: `initDone` rises at the later of two points: DLL_LOCK_CYC cycles after the DLL-reset MR, or TMRD_CYC cycles after the last EMR1 write. Once high it stays high.
- R10: A `start` pulse while a sequence runs or after it has finished has no effect on the command stream, on `cke` or on `initDone`.
- R11: Changes to the mode inputs after `start` has been accepted do not change any mode-register value that is written.
- R12: `odt` is held low throughout the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins initialization |
| burstLen | input | 3 | Burst length code for MR A2:A0 |
| casLat | input | 3 | CAS latency code for MR A6:A4 |
| addLat | input | 3 | Additive latency code for EMR1 A5:A3 |
| wrRec | input | 3 | Write-recovery code for MR A11:A9 |
| odtSel | input | 2 | Termination select for EMR1 A6 (bit 1) and A2 (bit 0) |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, selects the mode register |
| addr | output | ADDR_W | Address / mode-register value |
| odt | output | 1 | On-die termination control, held low |
| initDone | output | 1 | Initialization complete |

## Verification
The assertions assume that `start` is a clean pulse. They also assume the mode inputs are valid in the cycle it is sampled, and that every command gap is at least two cycles. The gap rule is enforced by clamping inside the block. The stimulus applies each configuration before raising `start`. In some runs it then scrambles the mode inputs and fires extra `start` pulses, both during the sequence and after `initDone`. This shows that neither disturbance reaches the issued stream. The configurations include all-zero and all-one codes, so every mode field is seen at both extremes, next to several seeded random mixes.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PREA,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    REG_MR   = 2'd0,
    REG_EMR1 = 2'd1,
    REG_EMR2 = 2'd2,
    REG_EMR3 = 2'd3
  } reg_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_PRECKE,
    ST_CKENOP,
    ST_PREA1,
    ST_EMR2,
    ST_EMR3,
    ST_EMR1,
    ST_MRDLL,
    ST_PREA2,
    ST_REF1,
    ST_REF2,
    ST_MR,
    ST_OCDDEF,
    ST_OCDEXIT,
    ST_WAIT,
    ST_LOCK,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    cmd_e cmd;
    reg_e regSel;
    logic dllRst;
    logic ocdDefault;
    logic ckeOn;
    logic doneOn;
    logic latchCfg;
  } strobe_t;

  typedef struct packed {
    logic [2:0] burstLen;
    logic [2:0] casLat;
    logic [2:0] addLat;
    logic [2:0] wrRec;
    logic [1:0] odtSel;
  } mode_cfg_t;

endpackage

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int PRE_CKE_CYC  = 50000,
  parameter int CKE_NOP_CYC  = 100,
  parameter int TRP_CYC      = 4,
  parameter int TRFC_CYC     = 27,
  parameter int TMRD_CYC     = 2,
  parameter int DLL_LOCK_CYC = 200
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strobe
);

  localparam int GAP_RP  = (TRP_CYC  < 2) ? 2 : TRP_CYC;
  localparam int GAP_RFC = (TRFC_CYC < 2) ? 2 : TRFC_CYC;
  localparam int GAP_MRD = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int PRE_LD  = (PRE_CKE_CYC < 1) ? 1 : PRE_CKE_CYC;
  localparam int NOP_LD  = (CKE_NOP_CYC < 1) ? 1 : CKE_NOP_CYC;
  localparam int LOCK_LD = (DLL_LOCK_CYC < 1) ? 1 : DLL_LOCK_CYC;
  localparam int CNT_W   = $clog2(PRE_LD + NOP_LD + GAP_RP + GAP_RFC + GAP_MRD + 2);
  localparam int LOCK_W  = $clog2(LOCK_LD + 2);

  seq_state_e        state;
  seq_state_e        retState;
  logic [CNT_W-1:0]  waitCnt;
  logic [LOCK_W-1:0] lockCnt;

  function automatic logic isCmdState(input seq_state_e s);
    return s inside {ST_PREA1, ST_EMR2, ST_EMR3, ST_EMR1, ST_MRDLL, ST_PREA2,
                     ST_REF1, ST_REF2, ST_MR, ST_OCDDEF, ST_OCDEXIT};
  endfunction

  function automatic seq_state_e succOf(input seq_state_e s);
    case (s)
      ST_PREA1:  return ST_EMR2;
      ST_EMR2:   return ST_EMR3;
      ST_EMR3:   return ST_EMR1;
      ST_EMR1:   return ST_MRDLL;
      ST_MRDLL:  return ST_PREA2;
      ST_PREA2:  return ST_REF1;
      ST_REF1:   return ST_REF2;
      ST_REF2:   return ST_MR;
      ST_MR:     return ST_OCDDEF;
      ST_OCDDEF: return ST_OCDEXIT;
      default:   return ST_LOCK;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] gapOf(input seq_state_e s);
    case (s)
      ST_PREA1, ST_PREA2: return CNT_W'(GAP_RP - 1);
      ST_REF1, ST_REF2:   return CNT_W'(GAP_RFC - 1);
      default:            return CNT_W'(GAP_MRD - 1);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      retState <= ST_IDLE;
      waitCnt  <= '0;
      lockCnt  <= '0;
    end else begin
      if (lockCnt != '0) lockCnt <= lockCnt - 1'b1;
      if (isCmdState(state)) begin
        waitCnt  <= gapOf(state);
        retState <= succOf(state);
        state    <= ST_WAIT;
        if (state == ST_MRDLL) lockCnt <= LOCK_W'(LOCK_LD - 1);
      end else begin
        case (state)
          ST_IDLE: if (start) begin
            state   <= ST_PRECKE;
            waitCnt <= CNT_W'(PRE_LD - 1);
          end
          ST_PRECKE: begin
            if (waitCnt == '0) begin
              state   <= ST_CKENOP;
              waitCnt <= CNT_W'(NOP_LD - 1);
            end else waitCnt <= waitCnt - 1'b1;
          end
          ST_CKENOP: begin
            if (waitCnt == '0) state <= ST_PREA1;
            else waitCnt <= waitCnt - 1'b1;
          end
          ST_WAIT: begin
            if (waitCnt <= CNT_W'(1)) state <= retState;
            else waitCnt <= waitCnt - 1'b1;
          end
          ST_LOCK: if (lockCnt == '0) state <= ST_DONE;
          default: state <= state;
        endcase
      end
    end
  end

  always_comb begin
    strobe.cmd        = CMD_NOP;
    strobe.regSel     = REG_MR;
    strobe.dllRst     = 1'b0;
    strobe.ocdDefault = 1'b0;
    strobe.ckeOn      = !(state inside {ST_IDLE, ST_PRECKE});
    strobe.doneOn     = (state == ST_DONE) || (state == ST_LOCK && lockCnt == '0);
    strobe.latchCfg   = (state == ST_IDLE) && start;
    case (state)
      ST_IDLE, ST_PRECKE: strobe.cmd = CMD_DESEL;
      ST_PREA1, ST_PREA2: strobe.cmd = CMD_PREA;
      ST_REF1, ST_REF2:   strobe.cmd = CMD_REF;
      ST_EMR2: begin strobe.cmd = CMD_MRS; strobe.regSel = REG_EMR2; end
      ST_EMR3: begin strobe.cmd = CMD_MRS; strobe.regSel = REG_EMR3; end
      ST_EMR1, ST_OCDEXIT: begin strobe.cmd = CMD_MRS; strobe.regSel = REG_EMR1; end
      ST_OCDDEF: begin
        strobe.cmd = CMD_MRS; strobe.regSel = REG_EMR1; strobe.ocdDefault = 1'b1;
      end
      ST_MRDLL: begin strobe.cmd = CMD_MRS; strobe.dllRst = 1'b1; end
      ST_MR:    strobe.cmd = CMD_MRS;
      default:  strobe.cmd = CMD_NOP;
    endcase
  end

  // R10: once started, the sequencer never falls back to its idle state
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_IDLE));

  // R9: completion is only reached after the lock window has drained
  a_r9_done_after_lock: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |-> (lockCnt == '0));

  // R3: every wait returns to a command or the lock state
  a_r3_wait_target: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (isCmdState(retState) || retState == ST_LOCK));

endmodule

// File: rtl/ddr2_init_datapath.sv
module ddr2_init_datapath
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int BA_W         = 2,
  parameter int TRFC_CYC     = 27,
  parameter int TMRD_CYC     = 2,
  parameter int DLL_LOCK_CYC = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  mode_cfg_t         cfgIn,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int GAP_RFC = (TRFC_CYC < 2) ? 2 : TRFC_CYC;
  localparam int GAP_MRD = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int LOCK_LD = (DLL_LOCK_CYC < 1) ? 1 : DLL_LOCK_CYC;
  localparam int GAP_CAP = ((GAP_RFC > GAP_MRD) ? GAP_RFC : GAP_MRD) + 1;
  localparam int GAP_W   = $clog2(GAP_CAP + 1);
  localparam int DLL_W   = $clog2(LOCK_LD + 2);

  mode_cfg_t         cfgQ;
  logic [3:0]        pinsNext;
  logic [BA_W-1:0]   baNext;
  logic [ADDR_W-1:0] addrNext;

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else if (strobe.latchCfg) cfgQ <= cfgIn;
  end

  always_comb begin
    addrNext = '0;
    baNext   = '0;
    case (strobe.cmd)
      CMD_DESEL: pinsNext = 4'b1111;
      CMD_PREA:  pinsNext = 4'b0010;
      CMD_REF:   pinsNext = 4'b0001;
      CMD_MRS:   pinsNext = 4'b0000;
      default:   pinsNext = 4'b0111;
    endcase
    if (strobe.cmd == CMD_PREA) addrNext[10] = 1'b1;
    if (strobe.cmd == CMD_MRS) begin
      baNext = BA_W'(strobe.regSel);
      case (strobe.regSel)
        REG_MR: begin
          addrNext[2:0]  = cfgQ.burstLen;
          addrNext[6:4]  = cfgQ.casLat;
          addrNext[8]    = strobe.dllRst;
          addrNext[11:9] = cfgQ.wrRec;
        end
        REG_EMR1: begin
          addrNext[2]    = cfgQ.odtSel[0];
          addrNext[5:3]  = cfgQ.addLat;
          addrNext[6]    = cfgQ.odtSel[1];
          addrNext[9:7]  = strobe.ocdDefault ? 3'b111 : 3'b000;
        end
        default: addrNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cke      <= 1'b0;
      {csN, rasN, casN, weN} <= 4'b1111;
      ba       <= '0;
      addr     <= '0;
      initDone <= 1'b0;
    end else begin
      cke      <= strobe.ckeOn;
      {csN, rasN, casN, weN} <= pinsNext;
      ba       <= baNext;
      addr     <= addrNext;
      initDone <= strobe.doneOn;
    end
  end

  // Spacing monitors on the issued pins
  logic             isMrs, isRef, isPrea, isCmd;
  logic [GAP_W-1:0] sinceMode, sinceRef;
  logic [DLL_W-1:0] sinceDll;

  assign isMrs  = ({csN, rasN, casN, weN} == 4'b0000);
  assign isRef  = ({csN, rasN, casN, weN} == 4'b0001);
  assign isPrea = ({csN, rasN, casN, weN} == 4'b0010);
  assign isCmd  = !csN && !(rasN && casN && weN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceMode <= GAP_W'(GAP_CAP);
      sinceRef  <= GAP_W'(GAP_CAP);
      sinceDll  <= '0;
    end else begin
      if (isMrs) sinceMode <= GAP_W'(1);
      else if (sinceMode < GAP_W'(GAP_CAP)) sinceMode <= sinceMode + 1'b1;
      if (isRef) sinceRef <= GAP_W'(1);
      else if (sinceRef < GAP_W'(GAP_CAP)) sinceRef <= sinceRef + 1'b1;
      if (isMrs && ba == '0 && addr[8]) sinceDll <= DLL_W'(1);
      else if (sinceDll != '0 && sinceDll < DLL_W'(LOCK_LD + 1)) sinceDll <= sinceDll + 1'b1;
    end
  end

  // R1, R2: with cke low only deselect is driven
  a_r2_cke_low_deselect: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> csN);

  // R4: precharge-all carries A10 high
  a_r4_prea_a10: assert property (@(posedge clk) disable iff (!rstN)
    isPrea |-> addr[10]);

  // R5: EMR3 is written with a zero payload
  a_r5_emr3_zero: assert property (@(posedge clk) disable iff (!rstN)
    (isMrs && ba == BA_W'(3)) |-> (addr == '0));

  // R8: mode writes are spaced by the mode-register gap
  a_r8_mrd_gap: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |-> (sinceMode >= GAP_W'(GAP_MRD)));

  // R8: nothing follows a refresh before the refresh gap
  a_r8_rfc_gap: assert property (@(posedge clk) disable iff (!rstN)
    isCmd |-> (sinceRef >= GAP_W'(GAP_RFC)));

  // R9: completion waits for the DLL lock window
  a_r9_lock_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (sinceDll >= DLL_W'(LOCK_LD)));

  // R9: completion is sticky
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int BA_W         = 2,
  parameter int PRE_CKE_CYC  = 50000,
  parameter int CKE_NOP_CYC  = 100,
  parameter int TRP_CYC      = 4,
  parameter int TRFC_CYC     = 27,
  parameter int TMRD_CYC     = 2,
  parameter int DLL_LOCK_CYC = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        burstLen,
  input  logic [2:0]        casLat,
  input  logic [2:0]        addLat,
  input  logic [2:0]        wrRec,
  input  logic [1:0]        odtSel,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              odt,
  output logic              initDone
);

  strobe_t   strobe;
  mode_cfg_t cfgIn;

  assign cfgIn.burstLen = burstLen;
  assign cfgIn.casLat   = casLat;
  assign cfgIn.addLat   = addLat;
  assign cfgIn.wrRec    = wrRec;
  assign cfgIn.odtSel   = odtSel;
  assign odt            = 1'b0;

  ddr2_init_ctrl #(
    .PRE_CKE_CYC (PRE_CKE_CYC),
    .CKE_NOP_CYC (CKE_NOP_CYC),
    .TRP_CYC     (TRP_CYC),
    .TRFC_CYC    (TRFC_CYC),
    .TMRD_CYC    (TMRD_CYC),
    .DLL_LOCK_CYC(DLL_LOCK_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe)
  );

  ddr2_init_datapath #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .TRFC_CYC    (TRFC_CYC),
    .TMRD_CYC    (TMRD_CYC),
    .DLL_LOCK_CYC(DLL_LOCK_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgIn   (cfgIn),
    .cke     (cke),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .ba      (ba),
    .addr    (addr),
    .initDone(initDone)
  );

endmodule

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;

  localparam int PRE    = 20;
  localparam int CKN    = 10;
  localparam int TRP    = 4;
  localparam int TRFC   = 9;
  localparam int TMRD   = 2;
  localparam int LOCK   = 200;
  localparam int RUNLEN = PRE + CKN + 320;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [2:0] bl = '0, cl = '0, al = '0, wr = '0;
  logic [1:0] od = '0;
  logic cke, csN, rasN, casN, weN, odt, initDone;
  logic [1:0]  ba;
  logic [12:0] addr;

  int  nTests = 0, nFail = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  ddr2_init_seq #(
    .PRE_CKE_CYC(PRE), .CKE_NOP_CYC(CKN), .TRP_CYC(TRP),
    .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .DLL_LOCK_CYC(LOCK)
  ) i_ddr2_init_seq (
    .clk(clk), .rstN(rstN), .start(start),
    .burstLen(bl), .casLat(cl), .addLat(al), .wrRec(wr), .odtSel(od),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .odt(odt), .initDone(initDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gapAfter(input int i);
    if (i == 0 || i == 5) return TRP;
    if (i == 6 || i == 7) return TRFC;
    return TMRD;
  endfunction

  function automatic logic [3:0] pinsOf(input int i);
    if (i == 0 || i == 5) return 4'b0010;
    if (i == 6 || i == 7) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic [1:0] baOf(input int i);
    case (i)
      1: return 2'd2;
      2: return 2'd3;
      3, 9, 10: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic string reqOf(input int i);
    case (i)
      0, 5: return "R4";
      1, 2: return "R5";
      4, 8: return "R6";
      3, 9, 10: return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [12:0] addrOf(input int i, input logic [2:0] b, input logic [2:0] c,
                                         input logic [2:0] a, input logic [2:0] w,
                                         input logic [1:0] o);
    case (i)
      0, 5: return 13'h0400;
      4:    return {1'b0, w, 1'b1, 1'b0, c, 1'b0, b};
      8:    return {1'b0, w, 1'b0, 1'b0, c, 1'b0, b};
      3, 10: return {3'b000, 3'b000, o[1], a, o[0], 2'b00};
      9:    return {3'b000, 3'b111, o[1], a, o[0], 2'b00};
      default: return 13'h0000;
    endcase
  endfunction

  task automatic runOne(input bit disturb);
    logic [2:0] eB, eC, eA, eW;
    logic [1:0] eO;
    int cmdK[16];
    logic [3:0] cp[16];
    logic [1:0] cb[16];
    logic [12:0] ca[16];
    int n = 0, ckeRise = -1, doneK = -1, badPre = 0, badNop = 0;
    int odtHigh = 0, ckeDrop = 0, doneDrop = 0, expDone;
    logic [31:0] r;
    for (int i = 0; i < 16; i++) begin cmdK[i] = 0; cp[i] = '1; cb[i] = '0; ca[i] = '0; end
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(cke == 1'b0, "R1 cke", int'(cke), 0);
    chk(csN == 1'b1, "R1 csN", int'(csN), 1);
    chk(initDone == 1'b0, "R1 done", int'(initDone), 0);
    chk(odt == 1'b0, "R1 odt", int'(odt), 0);
    eB = bl; eC = cl; eA = al; eW = wr; eO = od;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    for (int k = 1; k <= RUNLEN; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (odt) odtHigh++;
      if (k <= PRE && (cke || !csN)) badPre++;
      if (cke && ckeRise < 0) ckeRise = k;
      if (ckeRise >= 0 && !cke) ckeDrop++;
      if (!csN && !(rasN && casN && weN)) begin
        if (n < 16) begin
          cmdK[n] = k; cp[n] = {csN, rasN, casN, weN}; cb[n] = ba; ca[n] = addr;
        end
        n++;
      end else if (ckeRise >= 0 && csN) badNop++;
      if (initDone && doneK < 0) doneK = k;
      if (doneK >= 0 && !initDone) doneDrop++;
      if (disturb) begin
        if (k == 5) begin
          r = $urandom;
          {bl, cl, al, wr, od} = r[13:0];
        end
        start = (k == 40 || k == RUNLEN - 5);
      end
    end
    start = 1'b0;
    // R2: pre-CKE wait and NOP window
    chk(badPre == 0, "R2 deselect with cke low", badPre, 0);
    chk(ckeRise == PRE + 1, "R2 cke rise", ckeRise, PRE + 1);
    chk(cmdK[0] == PRE + CKN + 1, "R2 first command", cmdK[0], PRE + CKN + 1);
    chk(badNop == 0, "R2 NOP after cke", badNop, 0);
    // R3 and R10: exactly eleven commands, even with stray start pulses
    chk(n == 11, "R3 R10 command count", n, 11);
    for (int i = 0; i < 11; i++) begin
      chk(cp[i] == pinsOf(i), "R3 pins", int'(cp[i]), int'(pinsOf(i)));
      chk(cb[i] == baOf(i), reqOf(i), int'(cb[i]), int'(baOf(i)));
      chk(ca[i] == addrOf(i, eB, eC, eA, eW, eO), reqOf(i), int'(ca[i]),
          int'(addrOf(i, eB, eC, eA, eW, eO)));
    end
    // R8: exact spacing
    for (int i = 0; i < 10; i++)
      chk(cmdK[i+1] - cmdK[i] == gapAfter(i), "R8 gap", cmdK[i+1] - cmdK[i], gapAfter(i));
    // R9: completion point and stickiness
    expDone = (cmdK[4] + LOCK > cmdK[10] + TMRD) ? cmdK[4] + LOCK : cmdK[10] + TMRD;
    chk(doneK == expDone, "R9 done cycle", doneK, expDone);
    chk(doneDrop == 0, "R9 done held", doneDrop, 0);
    chk(odtHigh == 0, "R12 odt low", odtHigh, 0);
    chk(ckeDrop == 0, "R10 cke held", ckeDrop, 0);
    if (disturb) begin
      // R11: late mode-input changes do not leak into the written values
      chk(ca[8] == addrOf(8, eB, eC, eA, eW, eO), "R11 MR", int'(ca[8]),
          int'(addrOf(8, eB, eC, eA, eW, eO)));
      chk(ca[10] == addrOf(10, eB, eC, eA, eW, eO), "R11 EMR1", int'(ca[10]),
          int'(addrOf(10, eB, eC, eA, eW, eO)));
    end
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'd7321);
    for (int run = 0; run < 6; run++) begin
      if (run == 0) begin bl = 3'b111; cl = 3'b111; al = 3'b111; wr = 3'b111; od = 2'b11; end
      else if (run == 1) begin bl = '0; cl = '0; al = '0; wr = '0; od = '0; end
      else if (run == 2) begin bl = 3'd2; cl = 3'd5; al = 3'd1; wr = 3'd5; od = 2'b01; end
      else begin
        r = $urandom;
        {bl, cl, al, wr, od} = r[13:0];
      end
      runOne(run == 1 || run == 3 || run == 5);
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule